// File: doc/BRIEF.md
# Super I/O Configuration Index Port

This block is the configuration front end of a legacy Super I/O controller. A host sees a two-byte window: offset 0 is the index port and offset 1 is the data port. The window's base address is strapped outside this block. After reset the configuration space is closed. The host opens it by writing the open key 0x87 to the index port on two index writes in a row. It then writes a register number to the index port and moves bytes through the data port. Writing 0xAA to the index port closes the space again.

Register numbers below 0x30 reach global registers inside this block. Register 0x07 names the selected logical device. Register 0x1C is the pin-group function select, and its value is driven out to the pin multiplexing logic. Registers 0x20 and 0x21 return the high and low bytes of a parameterised chip ID. Register numbers from 0x30 up are passed on to the logical device named in register 0x07. Each such access raises a one-cycle read or write strobe that carries the device number, the register number and the write byte. The devices themselves and the host bus timing live outside this block.

Top module: `sio_cfg_port`

## Requirements
- R1: Reset leaves the space closed (`cfg_open`=0), device 0 selected (`ld_num`=0x00), `mf_sel` at its reset value (0x00), the index at 0x00 and `io_rdata`=0xFF.
- R2: Two index-port writes of 0x87 with no other index-port write between them open the space. `cfg_open` is 1 from the clock edge of the second write.
- R3: While one key has been seen, an index-port write of any other value restarts the sequence, so a following single 0x87 does not open the space. Data-port accesses do not disturb the sequence.
- R4: While the space is closed, data-port reads return 0xFF, data-port writes change no register, and no device strobe is raised.
- R5: While the space is open, an index-port write of 0xAA closes it from that clock edge. The index is left unchanged.
- R6: Register 0x20 reads CHIP_ID[15:8] and register 0x21 reads CHIP_ID[7:0]. Writes to either are ignored.
- R7: Register 0x07 is read/write, and its value drives `ld_num`.
- R8: Register 0x1C is read/write, and its value drives `mf_sel`.
- R9: The index holds until the next index-port write, so repeated data-port accesses reach the same register.
- R10: For an index of 0x30 or above, a data-port write raises `ld_wr` in the same cycle and a data-port read raises `ld_rd` in the same cycle. Either strobe carries `ld_idx`=index, `ld_num`=register 0x07 and `ld_wdata`=the write byte. The read returns `ld_rdata` on `io_rdata` after the next edge.
- R11: Global register numbers below 0x30 other than 0x07, 0x1C, 0x20 and 0x21 read 0x00, and writes to them are ignored.
- R12: Reads of the index port (offset 0) return the current index while the space is open and 0xFF while it is closed. Every read result appears on `io_rdata` one clock after the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 1 | Window offset: 0 index port, 1 data port |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access (never together with io_wr) |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read result |
| cfg_open | output | 1 | Configuration space is open |
| mf_sel | output | 8 | Pin-group function select (register 0x1C) |
| ld_num | output | 8 | Selected logical device (register 0x07) |
| ld_idx | output | 8 | Register number forwarded to the device |
| ld_wr | output | 1 | Device register write strobe |
| ld_rd | output | 1 | Device register read strobe |
| ld_wdata | output | 8 | Byte for the device write |
| ld_rdata | input | 8 | Device read byte, valid while ld_rd is high |

## Verification
Writes to the lock state, the index and registers 0x07 and 0x1C take effect at the edge that samples the access, so `cfg_open`, `ld_num` and `mf_sel` are due one edge later. Read results reach `io_rdata` one edge after the read strobe. Device strobes and their address and data are combinational and due in the same cycle as the host access. The bench drives each access just after a falling edge and checks the strobes 1 ns later against a behavioural model. It lets the rising edge update both the model and the design, then compares every registered output 1 ns after that edge, so every result is sampled in the cycle it is due.

// File: rtl/sio_cfg_pkg.sv
// Package: shared constants and types for the configuration index port.
// Assumes an 8-bit host data path and 8-bit register numbers.
package sio_cfg_pkg;
    localparam int DW = 8;

    // Window offsets
    localparam logic PORT_INDEX = 1'b0;
    localparam logic PORT_DATA  = 1'b1;

    // Global register numbers
    localparam logic [DW-1:0] REG_LDSEL = 8'h07;
    localparam logic [DW-1:0] REG_MFSEL = 8'h1C;
    localparam logic [DW-1:0] REG_ID_HI = 8'h20;
    localparam logic [DW-1:0] REG_ID_LO = 8'h21;

    // Value returned while configuration space is closed
    localparam logic [DW-1:0] CLOSED_READ = 8'hFF;

    // Lock sequencer states
    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_t;
endpackage

// File: rtl/sio_unlock_fsm.sv
// Module: lock sequencer. Watches index-port writes and opens configuration
// space after two consecutive open keys; a close key shuts it again.
// Assumes idx_wr is a single-cycle strobe. Data-port traffic is not seen here.
module sio_unlock_fsm
    import sio_cfg_pkg::*;
#(
    parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          cfg_open,
    output logic          idx_load
);
    lock_state_t state_q, state_d;

    // Next-state decode for index-port writes
    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                LK_CLOSED: state_d = (wdata == KEY_OPEN) ? LK_HALF : LK_CLOSED;
                LK_HALF:   state_d = (wdata == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
                LK_OPEN:   state_d = (wdata == KEY_CLOSE) ? LK_CLOSED : LK_OPEN;
                default:   state_d = LK_CLOSED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    assign cfg_open = (state_q == LK_OPEN);
    // An index write while open loads the index, unless it is the close key
    assign idx_load = idx_wr && (state_q == LK_OPEN) && (wdata != KEY_CLOSE);
endmodule

// File: rtl/sio_global_regs.sv
// Module: global register file below the device window. Holds the device
// select and pin-function select and decodes the read-only chip ID bytes.
// Assumes wr_en is qualified by open state and data-port selection.
module sio_global_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [2*DW-1:0] CHIP_ID  = 16'h1061,
    parameter logic [DW-1:0]   MF_RESET = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] idx,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ldsel,
    output logic [DW-1:0] mfsel,
    output logic [DW-1:0] rd_val
);
    localparam int ID_BYTES = 2;

    logic [ID_BYTES-1:0] id_hit;
    logic [DW-1:0]       id_byte [ID_BYTES];

    // One decoder per ID byte; byte 0 is the high byte at the lower number
    for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
        localparam logic [DW-1:0] ID_REG = REG_ID_HI + DW'(g);
        assign id_hit[g]  = (idx == ID_REG);
        assign id_byte[g] = CHIP_ID[(ID_BYTES-1-g)*DW +: DW];
    end

    // Writable global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldsel <= '0;
            mfsel <= MF_RESET;
        end else if (wr_en) begin
            if (idx == REG_LDSEL) ldsel <= wdata;
            if (idx == REG_MFSEL) mfsel <= wdata;
        end
    end

    // Read multiplexer; unimplemented numbers return zero
    always_comb begin
        rd_val = '0;
        if (idx == REG_LDSEL) rd_val = ldsel;
        if (idx == REG_MFSEL) rd_val = mfsel;
        for (int i = 0; i < ID_BYTES; i++) begin
            if (id_hit[i]) rd_val = id_byte[i];
        end
    end
endmodule

// File: rtl/sio_ld_router.sv
// Module: forwards data-port accesses at or above the window base to the
// selected logical device as single-cycle strobes. Purely combinational.
// Assumes the device returns read data in the cycle of its read strobe.
module sio_ld_router
    import sio_cfg_pkg::*;
#(
    parameter logic [DW-1:0] LD_BASE = 8'h30
) (
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] ldsel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dev_rdata,
    output logic          in_window,
    output logic          ld_wr,
    output logic          ld_rd,
    output logic [DW-1:0] ld_num,
    output logic [DW-1:0] ld_idx,
    output logic [DW-1:0] ld_wdata,
    output logic [DW-1:0] rd_val
);
    // Window decode and strobe generation
    always_comb begin
        in_window = (idx >= LD_BASE);
        ld_wr     = data_wr && in_window;
        ld_rd     = data_rd && in_window;
        ld_num    = ldsel;
        ld_idx    = idx;
        ld_wdata  = wdata;
        rd_val    = dev_rdata;
    end
endmodule

// File: rtl/sio_cfg_port.sv
// Module: top of the configuration index port. Holds the index and the
// registered read result, and ties the lock sequencer, global registers
// and device router together. Assumes io_rd and io_wr are never both high.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [2*DW-1:0] CHIP_ID   = 16'h1061,
    parameter logic [DW-1:0]   KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0]   KEY_CLOSE = 8'hAA,
    parameter logic [DW-1:0]   LD_BASE   = 8'h30,
    parameter logic [DW-1:0]   MF_RESET  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_sel,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          cfg_open,
    output logic [DW-1:0] mf_sel,
    output logic [DW-1:0] ld_num,
    output logic [DW-1:0] ld_idx,
    output logic          ld_wr,
    output logic          ld_rd,
    output logic [DW-1:0] ld_wdata,
    input  logic [DW-1:0] ld_rdata
);
    logic [DW-1:0] index_q;
    logic [DW-1:0] ldsel, glob_rd, dev_rd;
    logic          idx_load, in_window;
    logic          data_wr, data_rd;

    assign data_wr = io_wr && (io_sel == PORT_DATA) && cfg_open;
    assign data_rd = io_rd && (io_sel == PORT_DATA) && cfg_open;

    sio_unlock_fsm #(.KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && (io_sel == PORT_INDEX)),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    sio_global_regs #(.CHIP_ID(CHIP_ID), .MF_RESET(MF_RESET)) u_glob (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (index_q),
        .wr_en  (data_wr && !in_window),
        .wdata  (io_wdata),
        .ldsel  (ldsel),
        .mfsel  (mf_sel),
        .rd_val (glob_rd)
    );

    sio_ld_router #(.LD_BASE(LD_BASE)) u_route (
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .idx       (index_q),
        .ldsel     (ldsel),
        .wdata     (io_wdata),
        .dev_rdata (ld_rdata),
        .in_window (in_window),
        .ld_wr     (ld_wr),
        .ld_rd     (ld_rd),
        .ld_num    (ld_num),
        .ld_idx    (ld_idx),
        .ld_wdata  (ld_wdata),
        .rd_val    (dev_rd)
    );

    // Index register, loaded by index-port writes while open
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= '0;
        else if (idx_load) index_q <= io_wdata;
    end

    // Registered read result, updated on every host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= CLOSED_READ;
        end else if (io_rd) begin
            if (!cfg_open)                 io_rdata <= CLOSED_READ;
            else if (io_sel == PORT_INDEX) io_rdata <= index_q;
            else if (in_window)            io_rdata <= dev_rd;
            else                           io_rdata <= glob_rd;
        end
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
// Module: property checker for the configuration index port, bound to the
// top. Observes ports only.
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0] KEY_CLOSE = 8'hAA,
    parameter logic [DW-1:0] LD_BASE   = 8'h30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_sel,
    input logic          io_wr,
    input logic          io_rd,
    input logic [DW-1:0] io_wdata,
    input logic [DW-1:0] io_rdata,
    input logic          cfg_open,
    input logic [DW-1:0] ld_num,
    input logic [DW-1:0] ld_idx,
    input logic          ld_wr,
    input logic          ld_rd
);
    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && io_sel == PORT_INDEX && io_wdata == KEY_OPEN));

    // R5
    close_key_shuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && io_sel == PORT_INDEX && io_wdata == KEY_CLOSE) |=> !cfg_open);

    // R4
    closed_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> (!ld_wr && !ld_rd));

    // R4
    closed_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd) |=> (io_rdata == CLOSED_READ));

    // R10
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr || ld_rd) |-> (ld_idx >= LD_BASE));

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_wr, ld_rd}));

    // R7
    ldsel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_open && io_wr && io_sel == PORT_DATA) |=> $stable(ld_num));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .KEY_OPEN  (KEY_OPEN),
    .KEY_CLOSE (KEY_CLOSE),
    .LD_BASE   (LD_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_sel   (io_sel),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .cfg_open (cfg_open),
    .ld_num   (ld_num),
    .ld_idx   (ld_idx),
    .ld_wr    (ld_wr),
    .ld_rd    (ld_rd)
);

// File: tb/sio_cfg_port_tb.sv
// Bench: behavioural reference model compared on every clock.
module sio_cfg_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       io_sel, io_wr, io_rd;
    logic [7:0] io_wdata, io_rdata, mf_sel, ld_num, ld_idx, ld_wdata, ld_rdata;
    logic       cfg_open, ld_wr, ld_rd;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string req   = "R1";

    // Model state
    int       m_state = 0;   // 0 closed, 1 one key seen, 2 open
    bit [7:0] m_idx = 0, m_ldsel = 0, m_mf = 0, m_rd = 8'hFF;

    always #10 clk = ~clk;   // 50 MHz

    sio_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
        .mf_sel(mf_sel), .ld_num(ld_num), .ld_idx(ld_idx), .ld_wr(ld_wr),
        .ld_rd(ld_rd), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
    );

    // Stub device: read byte depends on device number and register number
    function automatic bit [7:0] dev_byte(bit [7:0] num, bit [7:0] idx);
        return 8'(num * 8'h11) ^ idx;
    endfunction
    assign ld_rdata = dev_byte(ld_num, ld_idx);

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One host cycle: drive, check strobes, update model, check registered outputs
    task automatic cyc(bit sel, bit wr, bit rd, bit [7:0] d);
        bit exp_wr, exp_rd;
        @(negedge clk);
        io_sel = sel; io_wr = wr; io_rd = rd; io_wdata = d;
        #1;
        exp_wr = (m_state == 2) && wr && sel && (m_idx >= 8'h30);
        exp_rd = (m_state == 2) && rd && sel && (m_idx >= 8'h30);
        chk("ld_wr", ld_wr, exp_wr);   // R10
        chk("ld_rd", ld_rd, exp_rd);   // R10
        if (exp_wr || exp_rd) begin
            chk("ld_idx", ld_idx, m_idx);
            chk("ld_num", ld_num, m_ldsel);
        end
        if (exp_wr) chk("ld_wdata", ld_wdata, d);
        @(posedge clk);
        if (rd) begin
            if (m_state != 2)  m_rd = 8'hFF;
            else if (!sel)     m_rd = m_idx;
            else if (m_idx >= 8'h30) m_rd = dev_byte(m_ldsel, m_idx);
            else case (m_idx)
                8'h07: m_rd = m_ldsel;
                8'h1C: m_rd = m_mf;
                8'h20: m_rd = 8'h10;
                8'h21: m_rd = 8'h61;
                default: m_rd = 8'h00;
            endcase
        end
        if (wr && !sel) begin
            case (m_state)
                0: m_state = (d == 8'h87) ? 1 : 0;
                1: m_state = (d == 8'h87) ? 2 : 0;
                default: if (d == 8'hAA) m_state = 0; else m_idx = d;
            endcase
        end else if (wr && sel && m_state == 2) begin
            if (m_idx == 8'h07) m_ldsel = d;
            if (m_idx == 8'h1C) m_mf = d;
        end
        #1;
        chk("cfg_open", cfg_open, m_state == 2);
        chk("io_rdata", io_rdata, m_rd);
        chk("ld_num",   ld_num,   m_ldsel);
        chk("mf_sel",   mf_sel,   m_mf);
    endtask

    task automatic iwr(bit [7:0] d); cyc(0, 1, 0, d); endtask
    task automatic dwr(bit [7:0] d); cyc(1, 1, 0, d); endtask
    task automatic drd();            cyc(1, 0, 1, 8'h00); endtask
    task automatic ird();            cyc(0, 0, 1, 8'h00); endtask
    task automatic idle();           cyc(0, 0, 0, 8'h00); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; io_sel = 0; io_wr = 0; io_rd = 0; io_wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        req = "R1";
        chk("cfg_open", cfg_open, 0);
        chk("io_rdata", io_rdata, 8'hFF);
        chk("ld_num", ld_num, 0);
        chk("mf_sel", mf_sel, 0);
        @(negedge clk); rst_n = 1;
        idle();

        // R4 closed: writes ignored, reads 0xFF, no strobes
        req = "R4";
        iwr(8'h07); dwr(8'h05); drd(); iwr(8'h40); dwr(8'h33); drd();
        req = "R12"; ird();

        // R3 interrupted sequence stays closed
        req = "R3";
        iwr(8'h87); drd(); iwr(8'h12); iwr(8'h87); idle();
        chk("still closed", cfg_open, 0);
        // R2 two keys open
        req = "R2";
        iwr(8'h87); dwr(8'h55); drd();
        chk("opened", cfg_open, 1);

        // R12 index left at reset value 0 after opening
        req = "R12"; ird();
        // R6 chip ID, writes ignored
        req = "R6";
        iwr(8'h20); drd(); dwr(8'h99); drd();
        iwr(8'h21); drd(); dwr(8'h00); drd();
        // R7 device select
        req = "R7";
        iwr(8'h07); dwr(8'h03); drd();
        // R8 and R9 function select, repeated accesses same register
        req = "R8";
        iwr(8'h1C); dwr(8'hA5); drd();
        req = "R9";
        drd(); dwr(8'h3C); drd(); dwr(8'hC3); drd();
        // R11 unimplemented globals
        req = "R11";
        iwr(8'h05); drd(); dwr(8'h77); drd(); iwr(8'h2F); dwr(8'h11); drd();
        // R10 device window
        req = "R10";
        iwr(8'h45); dwr(8'h5A); drd();
        iwr(8'h07); dwr(8'h09);
        iwr(8'h30); drd(); dwr(8'hE1); iwr(8'hFF); drd();
        // R12 index port read back
        req = "R12"; ird(); iwr(8'h2A); ird();
        // R5 close key
        req = "R5";
        iwr(8'hAA); drd(); dwr(8'h01); ird();
        req = "R4";
        iwr(8'h30); dwr(8'h22); drd();
        // Reopen, state retained
        req = "R2";
        iwr(8'h87); iwr(8'h87);
        req = "R5"; ird();
        req = "R7"; iwr(8'h07); drd();
        req = "R8"; iwr(8'h1C); drd();
        // Key value while open is just an index
        req = "R2"; iwr(8'h87); ird(); drd();
        idle();

        done = 1;
        summary();
        $finish;
    end
endmodule